// File: doc/BRIEF.md
# SPI NOR Flash Transaction Monitor

This block watches an SPI link between a host and a 25-series style NOR flash without driving it. An upstream deserializer gives it one event per completed byte, carrying both the host-driven value (MOSI) and the flash-driven value (MISO). A separate one-cycle pulse marks chip-select release. The monitor decodes each transaction against the byte sequence of its opcode. That sequence covers the address length, dummy bytes, two-line data phases and response bytes.

Each transaction produces one summary record on a valid/ready port when chip select is released. The record holds the opcode, the 24-bit address with a flag saying whether it is valid, the count of data bytes and a warning mask. If the consumer stalls, a newer record replaces the pending one and the newer record carries an overflow flag. Bit sampling, timing checks and the flash storage itself are not part of this block.

Top module: `flash_txn_monitor`

## Requirements
- R1: A record is presented with `rec_valid` high in the cycle after the clock edge that samples `cs_release`, but only if at least one byte arrived since the previous release. `rec_opcode` is the MOSI value of the first byte. A release with no bytes produces no record.
- R2: Opcodes 0x03 (read), 0x02 (page program), 0x20 (sector erase) and 0x0B (fast read) take the 3 bytes after the opcode as an address, most significant byte first. That address is reported with `rec_addr_valid` = 1.
- R3: For 0x03 and 0x02, `rec_count` counts the bytes from the 5th byte of the transaction up to the release.
- R4: For 0x0B, the 5th byte is a dummy byte and is not counted. Counting starts at the 6th byte.
- R5: For 0xBB (two-line fast read), each byte after the opcode is split into two logical bytes. The high logical byte has bit 2k from MOSI[4+k] and bit 2k+1 from MISO[4+k]. The low logical byte takes the same bit pattern from MOSI[k] and MISO[k]. The logical bytes, high first, then follow the 0x0B sequence. As a result, every raw byte from the 4th onward adds 2 to the count.
- R6: If a 0x20 address is complete and not a multiple of 4096, warning bit 2 is set.
- R7: For 0x05 (status read), every byte after the opcode is counted.
- R8: Any first byte other than the nine opcodes listed in R2, R5, R7 and R11 sets warning bit 0. Such a record has count 0, `rec_addr_valid` = 0 and `rec_addr` = 0, and any later bytes in that transaction have no effect on it.
- R9: If an address-carrying opcode is released before its address is complete, warning bit 1 is set, `rec_addr_valid` = 0 and `rec_addr` = 0.
- R10: While `rec_valid` is high and `rec_ready` is low, the record holds steady. If a new record arrives in that state, it replaces the old one and its `rec_overflow` bit is 1. Otherwise `rec_overflow` is 0.
- R11: 0x9F (identification read) counts every byte after the opcode. 0x90 (ID read with selector) counts from the 5th byte. 0x06 (write enable) has no address.
- R12: A byte that arrives in the same cycle as `cs_release` belongs to the transaction that is ending.
- R13: After reset, `rec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | A completed SPI byte is present |
| byte_mosi | input | 8 | Host-driven value of the byte |
| byte_miso | input | 8 | Flash-driven value of the byte |
| cs_release | input | 1 | Chip select deasserted this cycle |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_valid | output | 1 | Record is present |
| rec_opcode | output | 8 | First byte of the transaction |
| rec_addr | output | 24 | Assembled address, 0 if not valid |
| rec_addr_valid | output | 1 | Address was fully received |
| rec_count | output | COUNT_W | Data bytes counted |
| rec_warn | output | 3 | bit0 unknown, bit1 truncated, bit2 misaligned erase |
| rec_overflow | output | 1 | An unaccepted record was replaced |

## Verification
A record registers on the same edge that samples the release pulse. The bench therefore drives the release on a falling edge and reads every record field at the next falling edge. Bytes are driven one per cycle at falling edges, so each byte lands on exactly one rising edge. The stalled-consumer tests hold `rec_ready` low and read the record again one full cycle later to confirm it is still held. They then raise `rec_ready` and check that `rec_valid` drops one cycle later.

// File: rtl/flash_mon_pkg.sv
package flash_mon_pkg;

   localparam logic [7:0] OP_WREN = 8'h06;
   localparam logic [7:0] OP_RDSR = 8'h05;
   localparam logic [7:0] OP_READ = 8'h03;
   localparam logic [7:0] OP_FAST = 8'h0B;
   localparam logic [7:0] OP_DUAL = 8'hBB;
   localparam logic [7:0] OP_PROG = 8'h02;
   localparam logic [7:0] OP_SERA = 8'h20;
   localparam logic [7:0] OP_IDRD = 8'h9F;
   localparam logic [7:0] OP_IDSL = 8'h90;

   localparam int WARN_W     = 3;
   localparam int WB_UNKNOWN = 0;
   localparam int WB_TRUNC   = 1;
   localparam int WB_ALIGN   = 2;

   localparam int STAGE_W = 3;

   // Per-opcode byte sequence profile
   typedef struct packed {
      logic               known;
      logic               has_addr;
      logic               dual;
      logic               is_erase;
      logic               cnt_en;
      logic [STAGE_W-1:0] data_start; // bytes seen before the first counted byte
      logic [1:0]         step;       // logical bytes per counted raw byte
   } cmd_prof_t;

   // Rebuild one byte from a nibble of even bits and a nibble of odd bits
   function automatic logic [7:0] interleave(input logic [3:0] even, input logic [3:0] odd);
      logic [7:0] r;
      for (int k = 0; k < 4; k++) begin
         r[2*k]   = even[k];
         r[2*k+1] = odd[k];
      end
      return r;
   endfunction

endpackage

// File: rtl/fmon_cmd_class.sv
module fmon_cmd_class
   import flash_mon_pkg::*;
(
   input  logic [7:0] opcode,
   output cmd_prof_t  prof
);

   always_comb begin
      prof = '0;
      unique case (opcode)
         OP_READ, OP_PROG: begin
            prof.known = 1'b1; prof.has_addr = 1'b1; prof.cnt_en = 1'b1;
            prof.data_start = 3'd4; prof.step = 2'd1;
         end
         OP_FAST: begin
            prof.known = 1'b1; prof.has_addr = 1'b1; prof.cnt_en = 1'b1;
            prof.data_start = 3'd5; prof.step = 2'd1;
         end
         OP_DUAL: begin
            prof.known = 1'b1; prof.has_addr = 1'b1; prof.dual = 1'b1;
            prof.cnt_en = 1'b1; prof.data_start = 3'd3; prof.step = 2'd2;
         end
         OP_SERA: begin
            prof.known = 1'b1; prof.has_addr = 1'b1; prof.is_erase = 1'b1;
         end
         OP_RDSR, OP_IDRD, OP_WREN: begin
            prof.known = 1'b1; prof.cnt_en = 1'b1;
            prof.data_start = 3'd1; prof.step = 2'd1;
         end
         OP_IDSL: begin
            prof.known = 1'b1; prof.cnt_en = 1'b1;
            prof.data_start = 3'd4; prof.step = 2'd1;
         end
         default: prof = '0;
      endcase
   end

endmodule

// File: rtl/fmon_txn_tracker.sv
module fmon_txn_tracker
   import flash_mon_pkg::*;
#(
   parameter int COUNT_W      = 16,
   parameter int ADDR_W       = 24,
   parameter int ALIGN_BITS   = 12,
   parameter bit CNT_SATURATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               byte_valid,
   input  logic [7:0]         byte_mosi,
   input  logic [7:0]         byte_miso,
   input  logic               cs_release,
   output logic               done,
   output logic [7:0]         out_op,
   output logic [ADDR_W-1:0]  out_addr,
   output logic               out_addr_valid,
   output logic [COUNT_W-1:0] out_count,
   output logic [WARN_W-1:0]  out_warn
);

   localparam logic [STAGE_W-1:0] STAGE_MAX = '1;
   localparam logic [COUNT_W-1:0] CNT_MAX   = '1;

   if (COUNT_W < 4) begin : g_bad_count
      $error("COUNT_W too small");
   end
   if (ADDR_W != 24) begin : g_bad_addr
      $error("ADDR_W must be 24 (three address bytes)");
   end
   if (ALIGN_BITS < 1 || ALIGN_BITS >= ADDR_W) begin : g_bad_align
      $error("ALIGN_BITS out of range");
   end

   cmd_prof_t          prof_new, prof_q, n_prof;
   logic [STAGE_W-1:0] stage_q, n_stage;
   logic [7:0]         op_q, n_op;
   logic [ADDR_W-1:0]  addr_q, n_addr;
   logic               done_q, n_done;
   logic [COUNT_W-1:0] count_q, n_count, cnt_sum;
   logic [7:0]         dual_hi, dual_lo;

   fmon_cmd_class u_class (
      .opcode (byte_mosi),
      .prof   (prof_new)
   );

   assign dual_hi = interleave(byte_mosi[7:4], byte_miso[7:4]);
   assign dual_lo = interleave(byte_mosi[3:0], byte_miso[3:0]);

   // Count adder: saturating or wrapping, chosen at elaboration
   if (CNT_SATURATE) begin : g_sat
      logic [COUNT_W:0] wide;
      assign wide    = {1'b0, count_q} + {{(COUNT_W-1){1'b0}}, prof_q.step};
      assign cnt_sum = wide[COUNT_W] ? CNT_MAX : wide[COUNT_W-1:0];
   end else begin : g_wrap
      assign cnt_sum = count_q + {{(COUNT_W-2){1'b0}}, prof_q.step};
   end

   always_comb begin
      n_prof  = prof_q;
      n_stage = stage_q;
      n_op    = op_q;
      n_addr  = addr_q;
      n_done  = done_q;
      n_count = count_q;
      if (byte_valid) begin
         if (stage_q == '0) begin
            n_op    = byte_mosi;
            n_prof  = prof_new;
            n_stage = 3'd1;
            n_addr  = '0;
            n_done  = 1'b0;
            n_count = '0;
         end else begin
            if (stage_q != STAGE_MAX) n_stage = stage_q + 3'd1;
            if (prof_q.known) begin
               if (prof_q.has_addr && !done_q) begin
                  if (prof_q.dual) begin
                     if (stage_q == 3'd1) begin
                        n_addr = {addr_q[7:0], dual_hi, dual_lo};
                     end else begin
                        n_addr = {addr_q[15:0], dual_hi};
                        n_done = 1'b1;
                     end
                  end else begin
                     n_addr = {addr_q[15:0], byte_mosi};
                     if (stage_q == 3'd3) n_done = 1'b1;
                  end
               end
               if (prof_q.cnt_en && stage_q >= prof_q.data_start) n_count = cnt_sum;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prof_q  <= '0;
         stage_q <= '0;
         op_q    <= '0;
         addr_q  <= '0;
         done_q  <= 1'b0;
         count_q <= '0;
      end else if (cs_release) begin
         prof_q  <= '0;
         stage_q <= '0;
         op_q    <= '0;
         addr_q  <= '0;
         done_q  <= 1'b0;
         count_q <= '0;
      end else begin
         prof_q  <= n_prof;
         stage_q <= n_stage;
         op_q    <= n_op;
         addr_q  <= n_addr;
         done_q  <= n_done;
         count_q <= n_count;
      end
   end

   // Record built from the next-state view so a byte on the release cycle counts
   assign done           = cs_release && (n_stage != '0);
   assign out_op         = n_op;
   assign out_addr_valid = n_done;
   assign out_addr       = n_done ? n_addr : '0;
   assign out_count      = n_count;
   assign out_warn[WB_UNKNOWN] = !n_prof.known;
   assign out_warn[WB_TRUNC]   = n_prof.known && n_prof.has_addr && !n_done;
   assign out_warn[WB_ALIGN]   = n_prof.is_erase && n_done && (|n_addr[ALIGN_BITS-1:0]);

   // R3: within a transaction the data count never moves backwards
   p_count_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_release |=> count_q >= $past(count_q));

   // R2: once the address is complete it no longer changes
   p_addr_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !cs_release) |=> $stable(addr_q));

   // R8: an unrecognised opcode never completes an address or counts data
   p_unknown_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q != '0 && !prof_q.known) |-> (!done_q && count_q == '0));

endmodule

// File: rtl/fmon_rec_port.sv
module fmon_rec_port #(
   parameter int REC_W = 60
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [REC_W-1:0] push_data,
   input  logic             ready,
   output logic             valid,
   output logic [REC_W-1:0] data,
   output logic             overflow
);

   if (REC_W < 8) begin : g_bad_w
      $error("REC_W too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid    <= 1'b0;
         data     <= '0;
         overflow <= 1'b0;
      end else if (push) begin
         valid    <= 1'b1;
         data     <= push_data;
         overflow <= valid && !ready;
      end else if (valid && ready) begin
         valid    <= 1'b0;
      end
   end

   // R10: a stalled record stays unchanged
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready && !push) |=> (valid && $stable(data)));

   // R10: replacing a stalled record marks overflow
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (push && valid && !ready) |=> overflow);

endmodule

// File: rtl/flash_txn_monitor.sv
module flash_txn_monitor
   import flash_mon_pkg::*;
#(
   parameter int COUNT_W      = 16,
   parameter int ALIGN_BITS   = 12,
   parameter bit CNT_SATURATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               byte_valid,
   input  logic [7:0]         byte_mosi,
   input  logic [7:0]         byte_miso,
   input  logic               cs_release,
   input  logic               rec_ready,
   output logic               rec_valid,
   output logic [7:0]         rec_opcode,
   output logic [23:0]        rec_addr,
   output logic               rec_addr_valid,
   output logic [COUNT_W-1:0] rec_count,
   output logic [2:0]         rec_warn,
   output logic               rec_overflow
);

   localparam int ADDR_W = 24;
   localparam int REC_W  = 8 + ADDR_W + 1 + COUNT_W + WARN_W;

   logic               t_done, t_av;
   logic [7:0]         t_op;
   logic [ADDR_W-1:0]  t_addr;
   logic [COUNT_W-1:0] t_count;
   logic [WARN_W-1:0]  t_warn;
   logic [REC_W-1:0]   rec_in, rec_out;

   fmon_txn_tracker #(
      .COUNT_W      (COUNT_W),
      .ADDR_W       (ADDR_W),
      .ALIGN_BITS   (ALIGN_BITS),
      .CNT_SATURATE (CNT_SATURATE)
   ) u_track (
      .clk            (clk),
      .rst_n          (rst_n),
      .byte_valid     (byte_valid),
      .byte_mosi      (byte_mosi),
      .byte_miso      (byte_miso),
      .cs_release     (cs_release),
      .done           (t_done),
      .out_op         (t_op),
      .out_addr       (t_addr),
      .out_addr_valid (t_av),
      .out_count      (t_count),
      .out_warn       (t_warn)
   );

   assign rec_in = {t_op, t_addr, t_av, t_count, t_warn};

   fmon_rec_port #(.REC_W(REC_W)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (t_done),
      .push_data (rec_in),
      .ready     (rec_ready),
      .valid     (rec_valid),
      .data      (rec_out),
      .overflow  (rec_overflow)
   );

   assign {rec_opcode, rec_addr, rec_addr_valid, rec_count, rec_warn} = rec_out;

   // R1: a new record only appears after a chip-select release
   p_rec_after_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rec_valid) |-> $past(cs_release));

   // R9: an incomplete address is never reported as valid
   p_trunc_no_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> !(rec_warn[1] && rec_addr_valid));

endmodule

// File: tb/flash_txn_monitor_test.sv
module flash_txn_monitor_test;

   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          byte_valid = 1'b0;
   logic [7:0]    byte_mosi = '0;
   logic [7:0]    byte_miso = '0;
   logic          cs_release = 1'b0;
   logic          rec_ready = 1'b1;
   logic          rec_valid;
   logic [7:0]    rec_opcode;
   logic [23:0]   rec_addr;
   logic          rec_addr_valid;
   logic [CW-1:0] rec_count;
   logic [2:0]    rec_warn;
   logic          rec_overflow;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   always #2 clk = ~clk;

   flash_txn_monitor uut (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_mosi(byte_mosi),
      .byte_miso(byte_miso), .cs_release(cs_release), .rec_ready(rec_ready),
      .rec_valid(rec_valid), .rec_opcode(rec_opcode), .rec_addr(rec_addr),
      .rec_addr_valid(rec_addr_valid), .rec_count(rec_count), .rec_warn(rec_warn),
      .rec_overflow(rec_overflow)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // all drives start and end at a falling edge
   task automatic send(input logic [7:0] m, input logic [7:0] s);
      byte_valid = 1'b1; byte_mosi = m; byte_miso = s;
      @(negedge clk);
      byte_valid = 1'b0;
   endtask

   task automatic release_cs();
      cs_release = 1'b1;
      @(negedge clk);
      cs_release = 1'b0;
   endtask

   task automatic send_release(input logic [7:0] m, input logic [7:0] s);
      byte_valid = 1'b1; cs_release = 1'b1; byte_mosi = m; byte_miso = s;
      @(negedge clk);
      byte_valid = 1'b0; cs_release = 1'b0;
   endtask

   task automatic expect_rec(input string tag, input logic [7:0] op, input logic [23:0] a,
                             input logic av, input logic [CW-1:0] n, input logic [2:0] w,
                             input logic ov);
      chk({tag, " valid"}, rec_valid, 1'b1);
      chk({tag, " opcode"}, rec_opcode, op);
      chk({tag, " addr"}, rec_addr, a);
      chk({tag, " addr_valid"}, rec_addr_valid, av);
      chk({tag, " count"}, rec_count, n);
      chk({tag, " warn"}, rec_warn, w);
      chk({tag, " overflow"}, rec_overflow, ov);
      @(negedge clk);
   endtask

   task automatic send_addr(input logic [23:0] a);
      send(a[23:16], 8'h00);
      send(a[15:8], 8'h00);
      send(a[7:0], 8'h00);
   endtask

   // inverse of the two-line packing: even bits to MOSI, odd bits to MISO
   function automatic logic [15:0] dual_split(input logic [7:0] hi, input logic [7:0] lo);
      logic [7:0] m, s;
      m = {hi[6], hi[4], hi[2], hi[0], lo[6], lo[4], lo[2], lo[0]};
      s = {hi[7], hi[5], hi[3], hi[1], lo[7], lo[5], lo[3], lo[1]};
      return {m, s};
   endfunction

   task automatic t_reset();
      chk("R13 reset valid", rec_valid, 1'b0);
      release_cs();
      chk("R1 empty release no record", rec_valid, 1'b0);
   endtask

   task automatic t_read();
      send(8'h03, 8'h00); send_addr(24'hA1B2C3);
      for (int i = 0; i < 4; i++) send(8'h00, 8'h5A);
      release_cs();
      expect_rec("R2 R3 read", 8'h03, 24'hA1B2C3, 1'b1, 4, 3'b000, 1'b0);
      chk("R1 accepted record drops", rec_valid, 1'b0);
   endtask

   task automatic t_fast();
      send(8'h0B, 8'h00); send_addr(24'h00FF10); send(8'hEE, 8'h00);
      for (int i = 0; i < 3; i++) send(8'h00, 8'h11);
      release_cs();
      expect_rec("R4 fast read", 8'h0B, 24'h00FF10, 1'b1, 3, 3'b000, 1'b0);
   endtask

   task automatic t_dual();
      logic [15:0] p;
      send(8'hBB, 8'h00);
      p = dual_split(8'h12, 8'h34); send(p[15:8], p[7:0]);
      p = dual_split(8'h56, 8'hC3); send(p[15:8], p[7:0]);
      for (int i = 0; i < 3; i++) begin
         p = dual_split(8'h9A, 8'h7E); send(p[15:8], p[7:0]);
      end
      release_cs();
      expect_rec("R5 dual read", 8'hBB, 24'h123456, 1'b1, 6, 3'b000, 1'b0);
   endtask

   task automatic t_erase();
      send(8'h20, 8'h00); send_addr(24'h003000); release_cs();
      expect_rec("R6 erase aligned", 8'h20, 24'h003000, 1'b1, 0, 3'b000, 1'b0);
      send(8'h20, 8'h00); send_addr(24'h003010); release_cs();
      expect_rec("R6 erase misaligned", 8'h20, 24'h003010, 1'b1, 0, 3'b100, 1'b0);
   endtask

   task automatic t_status();
      send(8'h05, 8'h00);
      for (int i = 0; i < 5; i++) send(8'h00, 8'h03);
      release_cs();
      expect_rec("R7 status read", 8'h05, 24'h0, 1'b0, 5, 3'b000, 1'b0);
   endtask

   task automatic t_unknown();
      send(8'hAA, 8'h00);
      for (int i = 0; i < 5; i++) send(8'h12, 8'h34);
      release_cs();
      expect_rec("R8 unknown", 8'hAA, 24'h0, 1'b0, 0, 3'b001, 1'b0);
   endtask

   task automatic t_trunc();
      send(8'h03, 8'h00); send(8'h44, 8'h00); send(8'h55, 8'h00); release_cs();
      expect_rec("R9 truncated read", 8'h03, 24'h0, 1'b0, 0, 3'b010, 1'b0);
   endtask

   task automatic t_ids();
      send(8'h9F, 8'h00);
      for (int i = 0; i < 3; i++) send(8'h00, 8'hC2);
      release_cs();
      expect_rec("R11 id read", 8'h9F, 24'h0, 1'b0, 3, 3'b000, 1'b0);
      send(8'h90, 8'h00); send(8'h00, 8'h00); send(8'h00, 8'h00); send(8'h01, 8'h00);
      send(8'h00, 8'hC2); send(8'h00, 8'h17);
      release_cs();
      expect_rec("R11 id select", 8'h90, 24'h0, 1'b0, 2, 3'b000, 1'b0);
   endtask

   task automatic t_same_cycle();
      send(8'h02, 8'h00); send_addr(24'h0A0B0C);
      send(8'h11, 8'h00); send(8'h22, 8'h00);
      send_release(8'h33, 8'h00);
      expect_rec("R12 byte with release", 8'h02, 24'h0A0B0C, 1'b1, 3, 3'b000, 1'b0);
   endtask

   task automatic t_overflow();
      rec_ready = 1'b0;
      send(8'h06, 8'h00); release_cs();
      chk("R11 wren valid", rec_valid, 1'b1);
      chk("R11 wren opcode", rec_opcode, 8'h06);
      chk("R10 first no overflow", rec_overflow, 1'b0);
      @(negedge clk);
      chk("R10 held valid", rec_valid, 1'b1);
      chk("R10 held opcode", rec_opcode, 8'h06);
      send(8'h05, 8'h00); send(8'h00, 8'h01); send(8'h00, 8'h01); release_cs();
      chk("R10 replaced opcode", rec_opcode, 8'h05);
      chk("R10 replaced count", rec_count, 16'd2);
      chk("R10 overflow set", rec_overflow, 1'b1);
      rec_ready = 1'b1;
      @(negedge clk);
      chk("R10 drained", rec_valid, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read();
      t_fast();
      t_dual();
      t_erase();
      t_status();
      t_unknown();
      t_trunc();
      t_ids();
      t_same_cycle();
      t_overflow();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule